// File: doc/BRIEF.md
# Associative Page-Frame Register Lookup

This block translates an effective address into a physical address by a fully associative search. Primary memory is split into page frames, and each frame owns one register. The register holds the virtual page number now resident in that frame and a valid bit. The page-number field of an incoming request is compared against every frame register in the same cycle. A match gives the frame index. That index, joined with the unchanged in-page word offset, forms the physical address.

When nothing matches, the block raises a page-fault indication instead of a hit, so that the access is stopped and the instruction can be restarted. A fault handler uses a load port to install a page number, with or without the valid bit, into any chosen frame register. The block holds no page-transfer logic and no replacement policy. Frame choice and data movement belong to the handler.

Default geometry: 32 frames, 512-word pages (9-bit offset), 11-bit virtual page numbers, so a 20-bit effective address and a 14-bit physical address.

Top module: `pfr_lookup`

## Requirements
- R1: After reset every frame register is invalid and all response outputs are 0, so any request made after reset faults.
- R2: A load writes `ld_vpn` and `ld_valid` into frame `ld_frame` at the clock edge. A request in the same cycle as the load is translated against the old contents, and a request one cycle later sees the new mapping.
- R3: A request whose page number (address bits [19:9]) matches a valid register produces, one cycle later, `rsp_hit`=1 and `rsp_paddr` = {frame index (bits [13:9]), request offset (bits [8:0])}.
- R4: A request that matches no valid register produces, one cycle later, `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R5: A register whose valid bit is 0 never matches, even when its stored page number equals the request's page number.
- R6: When several valid registers match, the lowest-numbered frame supplies the physical address and `rsp_multi` is 1. With a single match, `rsp_multi` is 0.
- R7: `rsp_valid` equals `req_valid` of the previous cycle. In a cycle after no request, `rsp_hit`, `rsp_fault`, `rsp_multi` and `rsp_paddr` are all 0.
- R8: `rsp_hit` and `rsp_fault` are never both 1, and exactly one of them is 1 whenever `rsp_valid` is 1.
- R9: Loading a new page number into an occupied frame replaces the old one, and the old page number then faults unless another frame holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 20 | Effective address: page number [19:9], offset [8:0] |
| ld_en | input | 1 | Write one frame register |
| ld_frame | input | 5 | Frame register to write |
| ld_vpn | input | 11 | Page number to install |
| ld_valid | input | 1 | Valid bit to install |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_hit | output | 1 | The request matched a valid frame |
| rsp_fault | output | 1 | Page fault: no valid frame matched |
| rsp_multi | output | 1 | More than one valid frame matched |
| rsp_paddr | output | 14 | Frame index joined with word offset; 0 unless hit |

## Verification
The hardest state to reach is a duplicate mapping. No correct handler would create one, yet it is the only way to see the priority choice and the multiple-hit flag. The stimulus table installs the same page number into a high frame while a lower frame still holds it. It then clears the lower frame's valid bit and shows that the higher frame takes over with the flag dropped. The same-cycle load-plus-request rows pin down exactly when a new mapping becomes visible.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
    typedef struct packed {
        logic valid;
        logic hit;
        logic fault;
        logic multi;
    } rsp_flags_t;
endpackage

// File: rtl/pfr_regfile.sv
module pfr_regfile #(
    parameter int NUM_FRAMES = 32,
    parameter int VPN_W      = 11,
    localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_en,
    input  logic [FIDX_W-1:0]                ld_frame,
    input  logic [VPN_W-1:0]                 ld_vpn,
    input  logic                             ld_valid,
    output logic [NUM_FRAMES-1:0][VPN_W-1:0] frame_vpn,
    output logic [NUM_FRAMES-1:0]            frame_vld
);
    logic [NUM_FRAMES-1:0][VPN_W-1:0] vpn_d, vpn_q;
    logic [NUM_FRAMES-1:0]            vld_d, vld_q;

    always_comb begin
        vpn_d = vpn_q;
        vld_d = vld_q;
        if (ld_en) begin
            vpn_d[ld_frame] = ld_vpn;
            vld_d[ld_frame] = ld_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            vld_q <= '0;
        end else begin
            vpn_q <= vpn_d;
            vld_q <= vld_d;
        end
    end

    assign frame_vpn = vpn_q;
    assign frame_vld = vld_q;
endmodule

// File: rtl/pfr_match.sv
module pfr_match #(
    parameter int NUM_FRAMES = 32,
    parameter int VPN_W      = 11
) (
    input  logic [VPN_W-1:0]                 probe_vpn,
    input  logic [NUM_FRAMES-1:0][VPN_W-1:0] frame_vpn,
    input  logic [NUM_FRAMES-1:0]            frame_vld,
    output logic [NUM_FRAMES-1:0]            match_vec
);
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign match_vec[g] = frame_vld[g] && (frame_vpn[g] == probe_vpn);
    end
endmodule

// File: rtl/pfr_prio.sv
module pfr_prio #(
    parameter int NUM_FRAMES = 32,
    localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0] match_vec,
    output logic                  any_hit,
    output logic                  many_hit,
    output logic [FIDX_W-1:0]     win_idx
);
    always_comb begin
        win_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match_vec[i]) win_idx = FIDX_W'(i);
        end
    end

    assign any_hit  = |match_vec;
    assign many_hit = |(match_vec & (match_vec - NUM_FRAMES'(1)));
endmodule

// File: rtl/pfr_lookup.sv
module pfr_lookup #(
    parameter int NUM_FRAMES = 32,
    parameter int VPN_W      = 11,
    parameter int OFS_W      = 9,
    localparam int FIDX_W    = $clog2(NUM_FRAMES),
    localparam int EA_W      = VPN_W + OFS_W,
    localparam int PA_W      = FIDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_addr,
    input  logic              ld_en,
    input  logic [FIDX_W-1:0] ld_frame,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic              ld_valid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_paddr
);
    import pfr_pkg::*;

    typedef struct packed {
        rsp_flags_t      flags;
        logic [PA_W-1:0] paddr;
    } rsp_state_t;

    logic [NUM_FRAMES-1:0][VPN_W-1:0] frame_vpn;
    logic [NUM_FRAMES-1:0]            frame_vld;
    logic [NUM_FRAMES-1:0]            match_vec;
    logic                             any_hit, many_hit;
    logic [FIDX_W-1:0]                win_idx;
    rsp_state_t                       s_d, s_q;

    pfr_regfile #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_frame(ld_frame), .ld_vpn(ld_vpn), .ld_valid(ld_valid),
        .frame_vpn(frame_vpn), .frame_vld(frame_vld)
    );

    pfr_match #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) u_match (
        .probe_vpn(req_addr[EA_W-1:OFS_W]),
        .frame_vpn(frame_vpn), .frame_vld(frame_vld),
        .match_vec(match_vec)
    );

    pfr_prio #(.NUM_FRAMES(NUM_FRAMES)) u_prio (
        .match_vec(match_vec), .any_hit(any_hit),
        .many_hit(many_hit), .win_idx(win_idx)
    );

    always_comb begin
        s_d = '0;
        if (req_valid) begin
            s_d.flags.valid = 1'b1;
            s_d.flags.hit   = any_hit;
            s_d.flags.fault = !any_hit;
            s_d.flags.multi = many_hit;
            if (any_hit) s_d.paddr = {win_idx, req_addr[OFS_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.flags.valid;
    assign rsp_hit   = s_q.flags.hit;
    assign rsp_fault = s_q.flags.fault;
    assign rsp_multi = s_q.flags.multi;
    assign rsp_paddr = s_q.paddr;
endmodule

// File: rtl/pfr_lookup_chk.sv
module pfr_lookup_chk #(
    parameter int OFS_W = 9,
    parameter int EA_W  = 20,
    parameter int PA_W  = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [EA_W-1:0] req_addr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic            rsp_multi,
    input logic [PA_W-1:0] rsp_paddr
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid)));

    // R8
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R8
    outcome_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == (rsp_hit || rsp_fault));

    // R6
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

    // R4
    fault_zero_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_hit) |-> (rsp_paddr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));
endmodule

bind pfr_lookup pfr_lookup_chk #(.OFS_W(OFS_W), .EA_W(EA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
);

// File: tb/pfr_lookup_tb.sv
module pfr_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_frame = '0;
    logic [10:0] ld_vpn = '0;
    logic        ld_valid = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
    logic [13:0] rsp_paddr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pfr_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .ld_en(ld_en), .ld_frame(ld_frame), .ld_vpn(ld_vpn), .ld_valid(ld_valid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
    );

    typedef struct packed {
        logic        ld;
        logic [4:0]  lf;
        logic [10:0] lv;
        logic        lval;
        logic        rq;
        logic [10:0] rvpn;
        logic [8:0]  rofs;
        logic        eh;
        logic        ef;
        logic        em;
        logic [4:0]  eframe;
        logic [3:0]  rtag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h005, 9'h003, 1'b0, 1'b1, 1'b0, 5'd0,  4'd1}, // R1
        '{1'b1, 5'd3,  11'h005, 1'b1, 1'b1, 11'h005, 9'h007, 1'b0, 1'b1, 1'b0, 5'd0,  4'd2}, // R2 old view
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h005, 9'h1FF, 1'b1, 1'b0, 1'b0, 5'd3,  4'd2}, // R2 new view
        '{1'b1, 5'd0,  11'h7FF, 1'b1, 1'b0, 11'h7FF, 9'h000, 1'b0, 1'b0, 1'b0, 5'd0,  4'd7}, // R7
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h7FF, 9'h000, 1'b1, 1'b0, 1'b0, 5'd0,  4'd3}, // R3
        '{1'b1, 5'd31, 11'h123, 1'b1, 1'b1, 11'h124, 9'h001, 1'b0, 1'b1, 1'b0, 5'd0,  4'd4}, // R4
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h123, 9'h055, 1'b1, 1'b0, 1'b0, 5'd31, 4'd3}, // R3
        '{1'b1, 5'd10, 11'h005, 1'b1, 1'b1, 11'h005, 9'h002, 1'b1, 1'b0, 1'b0, 5'd3,  4'd6}, // R6 single
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h005, 9'h002, 1'b1, 1'b0, 1'b1, 5'd3,  4'd6}, // R6 multi
        '{1'b1, 5'd3,  11'h005, 1'b0, 1'b1, 11'h005, 9'h009, 1'b1, 1'b0, 1'b1, 5'd3,  4'd6}, // R6 still old
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h005, 9'h009, 1'b1, 1'b0, 1'b0, 5'd10, 4'd5}, // R5
        '{1'b1, 5'd10, 11'h200, 1'b1, 1'b0, 11'h005, 9'h004, 1'b0, 1'b0, 1'b0, 5'd0,  4'd7}, // R7
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h005, 9'h004, 1'b0, 1'b1, 1'b0, 5'd0,  4'd9}, // R9 old gone
        '{1'b0, 5'd0,  11'h000, 1'b0, 1'b1, 11'h200, 9'h004, 1'b1, 1'b0, 1'b0, 5'd10, 4'd9}  // R9 new
    };

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] outs();
        return {rsp_valid, rsp_hit, rsp_fault, rsp_multi, rsp_paddr};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", outs(), 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", outs(), 18'h0);

        for (int i = 0; i < NV; i++) begin
            ld_en     = VEC[i].ld;
            ld_frame  = VEC[i].lf;
            ld_vpn    = VEC[i].lv;
            ld_valid  = VEC[i].lval;
            req_valid = VEC[i].rq;
            req_addr  = {VEC[i].rvpn, VEC[i].rofs};
            @(negedge clk);
            ld_en = 1'b0;
            req_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[i].rtag, i), outs(),
                  {VEC[i].rq, VEC[i].eh, VEC[i].ef, VEC[i].em,
                   VEC[i].eh ? {VEC[i].eframe, VEC[i].rofs} : 14'h0});
        end

        // R7 no request after a request
        @(negedge clk);
        check("R7 quiet cycle", outs(), 18'h0);

        // R1 reset in the middle clears mappings
        req_valid = 1'b1;
        req_addr  = {11'h200, 9'h011};
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 outputs held in reset", outs(), 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mapping cleared by reset", outs(), {1'b1, 1'b0, 1'b1, 1'b0, 14'h0});

        // R5 load with valid=0 into empty frame holding matching number
        req_valid = 1'b0;
        ld_en = 1'b1; ld_frame = 5'd7; ld_vpn = 11'h200; ld_valid = 1'b0;
        @(negedge clk);
        ld_en = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 invalid entry ignored", outs(), {1'b1, 1'b0, 1'b1, 1'b0, 14'h0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule